// File: doc/BRIEF.md
# Clock-Stop Serial Trace Transmitter

This block takes trace messages, each an 8-bit address with either a 16-bit or an 8-bit data word, from a valid/ready input. It sends every message as a burst of nibbles on a narrow output port, which has 1, 2 or 4 data lines and a trace clock that the block generates. Each burst opens with two fixed nibbles. The address follows, high nibble first, and then the data nibbles from the most significant down. The short form leaves out the two upper data nibbles. On ports narrower than 4 lines, each nibble goes out most-significant bit first over 4 or 2 transfer slots.

The trace clock is not free-running. It rests high and begins every burst with a falling edge. It stops as soon as no further message is queued. In dual-edge timing the clock changes on every slot. In single-edge timing a receiver captures on the falling edge only, so each slot lasts a full clock period. The divider sets the length of a half period to cfg_rate+1 functional clock cycles. The configuration inputs are static, and the block captures them when it accepts a message.

The control is a three-state machine. ST_IDLE holds the clock high. ST_SLOT is the phase that begins with a clock edge and new data. ST_RISE is the second half of a single-edge slot. The transitions are:
- ST_IDLE to ST_SLOT when a message is accepted.
- ST_SLOT to ST_RISE at the end of a phase in single-edge timing.
- ST_SLOT to ST_SLOT at the end of a dual-edge slot. This covers both the next slot and a message accepted back-to-back.
- ST_RISE to ST_SLOT at the end of the second half of a single-edge slot, for the next slot or a back-to-back message.
- ST_SLOT or ST_RISE to ST_IDLE after the final slot when no message is waiting.

Top module: `trace_serial_tx`

## Requirements
- R1: While reset is asserted and afterwards in idle, trc_clk is 1, trc_dat is 0 and msg_ready is 1.
- R2: A message with msg_wide=1 is sent as 8 nibbles in this order: 4'b0100, 4'b1100, addr[7:4], addr[3:0], data[15:12], data[11:8], data[7:4], data[3:0].
- R3: A message with msg_wide=0 is sent as 6 nibbles: 4'b0100, 4'b1100, addr[7:4], addr[3:0], data[7:4], data[3:0].
- R4: cfg_lanes selects the port width. 0 sends one bit per slot on trc_dat[0]. 1 sends two bits per slot on trc_dat[1:0]. 2 or 3 sends a whole nibble on trc_dat[3:0]. Each nibble goes out MSB first, and lines that are not used stay 0.
- R5: With cfg_single_edge=0, trc_clk toggles at the start of every slot, together with the new data, and each slot lasts cfg_rate+1 clock cycles.
- R6: With cfg_single_edge=1, every slot starts with a falling edge and new data. trc_clk rises cfg_rate+1 cycles later, and the slot lasts 2*(cfg_rate+1) cycles.
- R7: On the clock edge that accepts a message (msg_valid and msg_ready both 1), trc_clk falls and the first slot's data appears.
- R8: After the final slot, trc_clk stays high and trc_dat keeps its last value, with no edge and no data change until the next acceptance.
- R9: msg_ready is 1 only in idle and in the last cycle of a message's final slot. A message offered then starts on the next cycle with no idle gap.
- R10: The width, edge mode and rate are captured when a message is accepted. Changing them during a message has no effect until the next message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | functional clock |
| rst_n | input | 1 | asynchronous active-low reset |
| cfg_rate | input | RATE_W | half-period divider; N gives N+1 cycles |
| cfg_single_edge | input | 1 | 1 selects falling-edge-only capture timing |
| cfg_lanes | input | 2 | port width code: 0 one line, 1 two lines, 2/3 four lines |
| msg_valid | input | 1 | a message is offered |
| msg_ready | output | 1 | the offered message is accepted this cycle |
| msg_addr | input | 8 | message address |
| msg_data | input | 16 | message data; only [7:0] used when msg_wide=0 |
| msg_wide | input | 1 | 1 for 16-bit data, 0 for 8-bit data |
| trc_clk | output | 1 | stoppable trace clock, rests high |
| trc_dat | output | 4 | trace data lines |

## Verification
The nibble order is checked with full and short messages whose address and data nibbles all differ from one another, so a swapped or dropped nibble shows up in the slot sequence. Each port width is run with values whose bit patterns are asymmetric, which exposes a reversed bit order or a wrong line. Several rates are run in both edge modes to tell the slot length in dual-edge timing apart from the half-slot rise in single-edge timing. Back-to-back messages, including one whose configuration is changed while it is being sent, show that there is no gap at the message boundary and that the configuration is captured at acceptance.

// File: rtl/trc_pkg.sv
`timescale 1ns/1ps
package trc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SLOT = 2'd1,
        ST_RISE = 2'd2
    } tx_state_e;

    localparam int          FRAME_BITS = 32;
    localparam int          SHORT_BITS = 24;
    localparam int          LEFT_W     = $clog2(FRAME_BITS + 1);
    localparam logic [7:0]  SYNC_BYTE  = 8'h4C;

    function automatic logic [FRAME_BITS-1:0] build_frame(
        input logic [7:0]  addr,
        input logic [15:0] data,
        input logic        wide
    );
        return wide ? {SYNC_BYTE, addr, data}
                    : {SYNC_BYTE, addr, data[7:0], 8'h00};
    endfunction

    function automatic logic [1:0] lane_log2(input logic [1:0] code);
        return (code == 2'd0) ? 2'd0 : (code == 2'd1) ? 2'd1 : 2'd2;
    endfunction
endpackage

// File: rtl/trc_phase_timer.sv
`timescale 1ns/1ps
module trc_phase_timer #(
    parameter int RATE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic [RATE_W-1:0] rate,
    output logic              done
);
    logic [RATE_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (restart)    cnt <= rate;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);

    // R5
    long_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && rate != '0) |=> !done);
endmodule

// File: rtl/trc_lane_shifter.sv
`timescale 1ns/1ps
module trc_lane_shifter
    import trc_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic                  shift,
    input  logic [FRAME_BITS-1:0] frame,
    input  logic                  wide,
    input  logic [1:0]            lanes,
    output logic [3:0]            lane_out,
    output logic                  last
);
    logic [FRAME_BITS-1:0] sreg;
    logic [1:0]            lg_q;
    logic [LEFT_W-1:0]     left;
    logic [2:0]            step;
    logic [LEFT_W-1:0]     total;

    assign step  = 3'd1 << lg_q;
    assign total = wide ? LEFT_W'(FRAME_BITS) : LEFT_W'(SHORT_BITS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg <= '0;
            lg_q <= '0;
            left <= '0;
        end else if (load) begin
            sreg <= frame;
            lg_q <= lane_log2(lanes);
            left <= total >> lane_log2(lanes);
        end else if (shift) begin
            sreg <= sreg << step;
            left <= left - 1'b1;
        end
    end

    always_comb begin
        unique case (lg_q)
            2'd0:    lane_out = {3'b000, sreg[FRAME_BITS-1]};
            2'd1:    lane_out = {2'b00, sreg[FRAME_BITS-1 -: 2]};
            default: lane_out = sreg[FRAME_BITS-1 -: 4];
        endcase
    end

    assign last = (left == LEFT_W'(1));

    // R9
    no_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift |-> (left > LEFT_W'(1)));
    // R10
    width_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(lg_q));
endmodule

// File: rtl/trace_serial_tx.sv
`timescale 1ns/1ps
module trace_serial_tx
    import trc_pkg::*;
#(
    parameter int RATE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RATE_W-1:0] cfg_rate,
    input  logic              cfg_single_edge,
    input  logic [1:0]        cfg_lanes,
    input  logic              msg_valid,
    output logic              msg_ready,
    input  logic [7:0]        msg_addr,
    input  logic [15:0]       msg_data,
    input  logic              msg_wide,
    output logic              trc_clk,
    output logic [3:0]        trc_dat
);
    tx_state_e         state, state_nx;
    logic              single_q;
    logic [RATE_W-1:0] rate_q;
    logic              phase_end, last, accept, slot_end, shift, restart;
    logic [RATE_W-1:0] timer_rate;

    assign slot_end  = phase_end && ((state == ST_RISE) || (state == ST_SLOT && !single_q));
    assign msg_ready = (state == ST_IDLE) || (slot_end && last);
    assign accept    = msg_valid && msg_ready;
    assign shift     = slot_end && !last;
    assign restart   = accept || shift || (state == ST_SLOT && single_q && phase_end);
    assign timer_rate = accept ? cfg_rate : rate_q;

    trc_phase_timer #(.RATE_W(RATE_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .rate    (timer_rate),
        .done    (phase_end)
    );

    trc_lane_shifter u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .shift    (shift),
        .frame    (build_frame(msg_addr, msg_data, msg_wide)),
        .wide     (msg_wide),
        .lanes    (cfg_lanes),
        .lane_out (trc_dat),
        .last     (last)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (accept) state_nx = ST_SLOT;
            ST_SLOT: begin
                if (phase_end) begin
                    if (single_q)       state_nx = ST_RISE;
                    else if (!last)     state_nx = ST_SLOT;
                    else if (msg_valid) state_nx = ST_SLOT;
                    else                state_nx = ST_IDLE;
                end
            end
            ST_RISE: begin
                if (phase_end) begin
                    if (!last || msg_valid) state_nx = ST_SLOT;
                    else                    state_nx = ST_IDLE;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trc_clk  <= 1'b1;
            single_q <= 1'b0;
            rate_q   <= '0;
        end else begin
            if (accept) begin
                single_q <= cfg_single_edge;
                rate_q   <= cfg_rate;
            end
            if (accept)
                trc_clk <= 1'b0;
            else if (shift)
                trc_clk <= single_q ? 1'b0 : ~trc_clk;
            else if (state == ST_SLOT && single_q && phase_end)
                trc_clk <= 1'b1;
        end
    end

    // R1
    idle_clk_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> trc_clk);
    // R7
    start_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_ready) |=> !trc_clk);
    // R8
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !msg_valid) |=> ($stable(trc_dat) && trc_clk));
    // R5
    dual_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLOT && !single_q && !phase_end) |=> $stable(trc_clk));
    // R9
    ready_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && !last) |-> !msg_ready);
endmodule

// File: tb/trace_serial_tx_bench.sv
`timescale 1ns/1ps
module trace_serial_tx_bench;
    typedef struct {
        logic [3:0] dat;
        bit         single;
        int         len;
        int         half;
        bit         first;
        int         start;
        string      tag;
    } slot_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  cfg_rate = '0;
    logic        cfg_single_edge = 1'b0;
    logic [1:0]  cfg_lanes = 2'd2;
    logic        msg_valid = 1'b0;
    logic        msg_ready;
    logic [7:0]  msg_addr = '0;
    logic [15:0] msg_data = '0;
    logic        msg_wide = 1'b0;
    logic        trc_clk;
    logic [3:0]  trc_dat;

    int    cyc = 0;
    int    errors = 0;
    int    checks = 0;
    bit    timeout = 0;
    slot_t q[$];
    logic [3:0] last_dat = '0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    trace_serial_tx u_trace_serial_tx (
        .clk(clk), .rst_n(rst_n), .cfg_rate(cfg_rate),
        .cfg_single_edge(cfg_single_edge), .cfg_lanes(cfg_lanes),
        .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_addr(msg_addr),
        .msg_data(msg_data), .msg_wide(msg_wide), .trc_clk(trc_clk), .trc_dat(trc_dat)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // scoreboard driver: expected slots computed from the message format
    task automatic push_msg(input logic [7:0] a, input logic [15:0] d, input bit wide,
                            input int acc, input string tag);
        logic [3:0] nib[8];
        int n = wide ? 8 : 6;
        int lw = (cfg_lanes == 2'd0) ? 1 : (cfg_lanes == 2'd1) ? 2 : 4;
        int half = int'(cfg_rate) + 1;
        bit firsty = 1;
        nib[0] = 4'b0100; nib[1] = 4'b1100; nib[2] = a[7:4]; nib[3] = a[3:0];
        if (wide) begin
            nib[4] = d[15:12]; nib[5] = d[11:8]; nib[6] = d[7:4]; nib[7] = d[3:0];
        end else begin
            nib[4] = d[7:4]; nib[5] = d[3:0]; nib[6] = '0; nib[7] = '0;
        end
        for (int i = 0; i < n; i++) begin
            for (int p = 0; p < 4 / lw; p++) begin
                slot_t it;
                if (lw == 4)      it.dat = nib[i];
                else if (lw == 2) it.dat = (nib[i] >> (2 - 2 * p)) & 4'h3;
                else              it.dat = (nib[i] >> (3 - p)) & 4'h1;
                it.single = cfg_single_edge;
                it.half   = half;
                it.len    = cfg_single_edge ? 2 * half : half;
                it.first  = firsty;
                it.start  = acc;
                it.tag    = tag;
                firsty    = 0;
                last_dat  = it.dat;
                q.push_back(it);
            end
        end
    endtask

    task automatic send(input logic [7:0] a, input logic [15:0] d, input bit wide,
                        input string tag);
        forever begin
            @(negedge clk); #1;
            if (msg_ready) break;
        end
        // R9: ready only once the previous message has no slots left
        chk(q.size() == 0, "R9", q.size(), 0);
        msg_addr = a; msg_data = d; msg_wide = wide; msg_valid = 1'b1;
        push_msg(a, d, wide, cyc + 1, tag);
        @(posedge clk); #1;
        msg_valid = 1'b0;
    endtask

    task automatic drain();
        while (q.size() != 0) @(negedge clk);
        repeat (40) @(negedge clk);
        // R8: stopped clock high, data held at the last slot
        chk(trc_clk == 1'b1, "R8", trc_clk, 1);
        chk(trc_dat == last_dat, "R8", trc_dat, last_dat);
        chk(msg_ready == 1'b1, "R1", msg_ready, 1);
        repeat (10) @(negedge clk);
    endtask

    // monitor
    logic prev_clk = 1'b1;
    logic [3:0] prev_dat = '0;
    bit   cur_single = 0, have_prev = 0, start_ev;
    int   prev_len = 0, cur_half = 0, last_start = 0;
    slot_t mit;

    always @(negedge clk) begin
        start_ev = 0;
        if (rst_n) begin
            if (trc_clk != prev_clk) begin
                if (!trc_clk || !cur_single) begin
                    start_ev = 1;
                    if (q.size() == 0) begin
                        chk(0, "R8", trc_clk, prev_clk);
                    end else begin
                        mit = q.pop_front();
                        if (mit.first) begin
                            chk(cyc == mit.start, "R7", cyc, mit.start);
                            chk(trc_clk == 1'b0, "R7", trc_clk, 0);
                        end else if (have_prev) begin
                            chk(cyc - last_start == prev_len, cur_single ? "R6" : "R5",
                                cyc - last_start, prev_len);
                        end
                        chk(trc_dat == mit.dat, mit.tag, trc_dat, mit.dat);
                        cur_single = mit.single;
                        prev_len   = mit.len;
                        cur_half   = mit.half;
                        last_start = cyc;
                        have_prev  = 1;
                    end
                end else begin
                    chk(cyc - last_start == cur_half, "R6", cyc - last_start, cur_half);
                end
            end
            if (trc_dat != prev_dat && !start_ev) chk(0, "R8", trc_dat, prev_dat);
        end
        prev_clk = trc_clk;
        prev_dat = trc_dat;
    end

    task automatic run_tests();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: values held in reset
        chk(trc_clk == 1'b1, "R1", trc_clk, 1);
        chk(trc_dat == 4'h0, "R1", trc_dat, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(msg_ready == 1'b1, "R1", msg_ready, 1);
        chk(trc_clk == 1'b1, "R1", trc_clk, 1);

        cfg_lanes = 2'd2; cfg_single_edge = 0; cfg_rate = 4'd0;
        send(8'h3A, 16'h9D61, 1, "R2"); drain();
        cfg_rate = 4'd2;
        send(8'hE5, 16'h00B7, 0, "R3"); drain();
        cfg_lanes = 2'd1; cfg_rate = 4'd1;
        send(8'h96, 16'h2CF1, 1, "R4"); drain();
        cfg_lanes = 2'd0; cfg_rate = 4'd0;
        send(8'hD2, 16'h0058, 0, "R4"); drain();
        cfg_lanes = 2'd3; cfg_rate = 4'd1;
        send(8'h71, 16'hA4E2, 1, "R4"); drain();
        cfg_lanes = 2'd2; cfg_single_edge = 1; cfg_rate = 4'd0;
        send(8'h5C, 16'h1E83, 1, "R6"); drain();
        cfg_lanes = 2'd1; cfg_rate = 4'd3;
        send(8'hA9, 16'h0036, 0, "R6"); drain();
        // R9: back-to-back messages
        cfg_lanes = 2'd2; cfg_single_edge = 0; cfg_rate = 4'd1;
        send(8'h12, 16'h3456, 1, "R9");
        send(8'hFE, 16'h00DC, 0, "R9");
        send(8'h87, 16'h6B29, 1, "R9"); drain();
        // R10: configuration changed while a message is in flight
        cfg_rate = 4'd2;
        send(8'hC3, 16'h7E14, 1, "R10");
        cfg_lanes = 2'd0; cfg_single_edge = 1; cfg_rate = 4'd0;
        send(8'h4B, 16'h00A5, 0, "R10");
        cfg_lanes = 2'd2; cfg_single_edge = 0; cfg_rate = 4'd3;
        drain();
    endtask

    initial begin
        fork
            run_tests();
            begin
                repeat (100000) @(posedge clk);
                timeout = 1;
            end
        join_any
        if (timeout) chk(0, "watchdog", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule